// File: doc/BRIEF.md
# Six-Pin Bidirectional I/O Port

This block is a memory-mapped bidirectional I/O port of six pins. Software reaches it through a small register bus. The bus has a write enable, a 2-bit address, write data and combinational read data. Behind the bus are three registers: an output latch, a per-pin direction mask, and a port view. The port view samples the live pin levels. Every pad gets a registered output value and an output enable, and each pad's input level is brought back through a two-flop synchronizer.

The port view and the latch view read back different things. The port view returns the pin levels, while the latch view returns what was last written, so read-modify-write sequences should go through the latch view. A write to either view lands in the same latch. A neighbouring analog configuration field drives a 4-bit code that marks some pins as analog. Analog pins read as zero through the port view, but their output drivers stay under the direction mask.

Top module: `bidir_port`

## Requirements
- R1: A synchronous reset sets the direction mask to all ones (every pin an input) and the latch to zero. In the cycle after reset, pad_oe is 6'h00 and pad_out is 6'h00.
- R2: A direction bit of 1 makes its pin an input (pad_oe bit 0). A bit of 0 drives the latch value onto the pin (pad_oe bit 1). pad_oe follows a direction write from the clock edge that takes the write.
- R3: A write at address 0 (port view) stores wdata[5:0] in the output latch. The new value shows on pad_out and in the address 1 readback after that edge.
- R4: A write at address 1 (latch view) stores wdata[5:0] in the same output latch, with the same timing as R3.
- R5: A read at address 1 returns the latched value in bits 5:0, whatever the pin levels are.
- R6: A read at address 0 returns the digital pin levels after two clock edges of synchronizer delay.
- R7: An analog-selected pin reads as 0 at address 0. After reset, and while the configuration code is below 7, pins 5 and 3..0 are analog and pin 4 is digital. A code of 7 or above makes every pin digital. The selection follows a code change one clock edge later.
- R8: pad_oe depends only on the direction mask. The analog selection never changes it.
- R9: Writes at address 3 change no register. Reads at address 3 return 0. Read bits 7:6 are always 0.
- R10: A write at address 2 stores wdata[5:0] as the direction mask, and a read at address 2 returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr | input | 2 | Register select: 0 port, 1 latch, 2 direction |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| ana_cfg | input | 4 | Analog configuration code from the neighbouring field |
| pad_in | input | 6 | Pin input levels |
| pad_out | output | 6 | Output value toward the pads |
| pad_oe | output | 6 | Output enable toward the pads, high drives |

## Verification
Two things can happen in the same clock edge: a write through the port view updates the latch, and the synchronizer captures a new pin level. The bench provokes this by driving a port-view write and a different pin pattern in the same cycle. It then checks three things: the latch view and pad_out show the written value after that edge; the port view still shows the old pins; and the port view shows the new pins one edge later. A second collision drives an analog code change in the same cycle as pin activity. In that case the masking must follow the code one edge later and leave pad_oe untouched.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_PORT = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ana_mask.sv
module gpio_ana_mask #(
  parameter int              WIDTH       = 6,
  parameter int              CFG_W       = 4,
  parameter int              DIGITAL_CFG = 7,
  parameter logic [WIDTH-1:0] ANALOG_PINS = 6'b101111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  output logic [WIDTH-1:0] analog_sel
);
  localparam logic [CFG_W-1:0] ALL_DIGITAL = CFG_W'(DIGITAL_CFG);

  logic [WIDTH-1:0] sel_next;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      sel_next[i] = ANALOG_PINS[i] && (cfg < ALL_DIGITAL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) analog_sel <= ANALOG_PINS;
    else     analog_sel <= sel_next;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 6,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [WIDTH-1:0]      lat_q,
  output logic [WIDTH-1:0]      dir_q
);
  reg_sel_e sel;
  logic     lat_we;
  logic     dir_we;

  assign sel    = reg_sel_e'(addr);
  assign lat_we = wr_en && (sel == SEL_PORT || sel == SEL_LAT);
  assign dir_we = wr_en && (sel == SEL_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_we) lat_q <= wdata[WIDTH-1:0];
      if (dir_we) dir_q <= wdata[WIDTH-1:0];
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 6,
  parameter int DATA_W = 8
) (
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]      pin_sync,
  input  logic [WIDTH-1:0]      analog_sel,
  input  logic [WIDTH-1:0]      lat_q,
  input  logic [WIDTH-1:0]      dir_q,
  output logic [DATA_W-1:0]     rdata
);
  logic [WIDTH-1:0] port_view;

  assign port_view = pin_sync & ~analog_sel;

  always_comb begin
    unique case (reg_sel_e'(addr))
      SEL_PORT: rdata = DATA_W'(port_view);
      SEL_LAT:  rdata = DATA_W'(lat_q);
      SEL_DIR:  rdata = DATA_W'(dir_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/bidir_port.sv
module bidir_port #(
  parameter int              WIDTH       = 6,
  parameter int              DATA_W      = 8,
  parameter int              CFG_W       = 4,
  parameter int              SYNC_STAGES = 2,
  parameter int              DIGITAL_CFG = 7,
  parameter logic [WIDTH-1:0] ANALOG_PINS = 6'b101111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CFG_W-1:0]  ana_cfg,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] analog_sel;

  gpio_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_ana_mask #(
    .WIDTH(WIDTH), .CFG_W(CFG_W), .DIGITAL_CFG(DIGITAL_CFG),
    .ANALOG_PINS(ANALOG_PINS)
  ) u_ana (
    .clk(clk), .rst(rst), .cfg(ana_cfg), .analog_sel(analog_sel)
  );

  gpio_rdmux #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_rd (
    .addr(addr), .pin_sync(pin_sync), .analog_sel(analog_sel),
    .lat_q(lat_q), .dir_q(dir_q), .rdata(rdata)
  );

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;
endmodule

// File: rtl/bidir_port_chk.sv
module bidir_port_chk #(
  parameter int              WIDTH       = 6,
  parameter int              DATA_W      = 8,
  parameter int              CFG_W       = 4,
  parameter int              DIGITAL_CFG = 7,
  parameter logic [WIDTH-1:0] ANALOG_PINS = 6'b101111
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [CFG_W-1:0]  ana_cfg,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe
);
  localparam logic [CFG_W-1:0] ALL_DIGITAL = CFG_W'(DIGITAL_CFG);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) && !rst |-> (pad_oe == '0) && (pad_out == '0));

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == 2'd2 |=> pad_oe == ~$past(wdata[WIDTH-1:0]));

  // R3
  port_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == 2'd0 |=> pad_out == $past(wdata[WIDTH-1:0]));

  // R4
  lat_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == 2'd1 |=> pad_out == $past(wdata[WIDTH-1:0]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en || addr == 2'd3 |=> $stable(pad_out) && $stable(pad_oe));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:WIDTH] == '0);

  // R7
  analog_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ana_cfg) < ALL_DIGITAL && addr == 2'd0 |->
      (rdata[WIDTH-1:0] & ANALOG_PINS) == '0);

  // R8
  oe_cfg_indep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pad_oe));
endmodule

bind bidir_port bidir_port_chk #(
  .WIDTH(WIDTH), .DATA_W(DATA_W), .CFG_W(CFG_W),
  .DIGITAL_CFG(DIGITAL_CFG), .ANALOG_PINS(ANALOG_PINS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ana_cfg(ana_cfg), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/bidir_port_test.sv
`timescale 1ns/1ps
module bidir_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] ana_cfg = 4'd0;
  logic [5:0] pad_in = 6'h00;
  logic [5:0] pad_out;
  logic [5:0] pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ana_cfg(ana_cfg), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; ana_cfg = 4'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    check("R1 oe", {2'b0, pad_oe}, 8'h00);
    check("R1 out", {2'b0, pad_out}, 8'h00);
    read_reg(2'd2, v); check("R1 dir", v, 8'h3F);
    read_reg(2'd1, v); check("R1 lat", v, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    write_reg(2'd2, 8'hC5);
    check("R2 oe", {2'b0, pad_oe}, 8'h3A);
    read_reg(2'd2, v); check("R10 dir readback", v, 8'h05);
    write_reg(2'd2, 8'h3F);
    check("R2 oe all input", {2'b0, pad_oe}, 8'h00);
  endtask

  task automatic t_port_write();
    logic [7:0] v;
    write_reg(2'd0, 8'hE9);
    check("R3 pad_out", {2'b0, pad_out}, 8'h29);
    read_reg(2'd1, v); check("R3 lat readback", v, 8'h29);
  endtask

  task automatic t_lat_write();
    logic [7:0] v;
    write_reg(2'd1, 8'h16);
    check("R4 pad_out", {2'b0, pad_out}, 8'h16);
    read_reg(2'd1, v); check("R4 lat readback", v, 8'h16);
  endtask

  task automatic t_lat_vs_pins();
    logic [7:0] v;
    ana_cfg = 4'd7;
    pad_in = 6'h29;
    repeat (3) @(negedge clk);
    read_reg(2'd1, v); check("R5 lat not pins", v, 8'h16);
    read_reg(2'd0, v); check("R6 pins", v, 8'h29);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    @(negedge clk); pad_in = 6'h12;
    @(posedge clk); #1;
    read_reg(2'd0, v); check("R6 one edge old", v, 8'h29);
    @(posedge clk); #1;
    read_reg(2'd0, v); check("R6 two edges new", v, 8'h12);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    do_reset();
    pad_in = 6'h3F;
    repeat (3) @(negedge clk);
    read_reg(2'd0, v); check("R7 reset mask", v, 8'h10);
    ana_cfg = 4'd6;
    @(negedge clk);
    read_reg(2'd0, v); check("R7 code 6", v, 8'h10);
    ana_cfg = 4'd7;
    @(posedge clk); #1;
    read_reg(2'd0, v); check("R7 code 7", v, 8'h3F);
    ana_cfg = 4'd15;
    @(negedge clk);
    read_reg(2'd0, v); check("R7 code 15", v, 8'h3F);
    ana_cfg = 4'd0;
    @(posedge clk); #1;
    read_reg(2'd0, v); check("R7 back to analog", v, 8'h10);
  endtask

  task automatic t_oe_indep();
    write_reg(2'd2, 8'h00);
    check("R8 oe analog", {2'b0, pad_oe}, 8'h3F);
    @(negedge clk); ana_cfg = 4'd7;
    repeat (2) @(negedge clk);
    check("R8 oe digital", {2'b0, pad_oe}, 8'h3F);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    write_reg(2'd1, 8'h0C);
    write_reg(2'd3, 8'hFF);
    check("R9 out kept", {2'b0, pad_out}, 8'h0C);
    check("R9 oe kept", {2'b0, pad_oe}, 8'h3F);
    read_reg(2'd3, v); check("R9 read 3", v, 8'h00);
    read_reg(2'd2, v); check("R9 dir kept", v, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    pad_in = 6'h00;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h2A; pad_in = 6'h15;
    @(negedge clk);
    wr_en = 1'b0;
    check("R3 collision out", {2'b0, pad_out}, 8'h2A);
    read_reg(2'd1, v); check("R3 collision lat", v, 8'h2A);
    read_reg(2'd0, v); check("R6 collision old pins", v, 8'h00);
    @(posedge clk); #1;
    read_reg(2'd0, v); check("R6 collision new pins", v, 8'h15);
  endtask

  initial begin
    t_reset();
    t_dir();
    t_port_write();
    t_lat_write();
    t_lat_vs_pins();
    t_latency();
    t_analog();
    t_oe_indep();
    t_unused();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule